// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the register file of a single descriptor-driven DMA channel. Software reaches it over a plain 32-bit register bus. The bus decodes a 128-byte channel window into word slots. The block keeps the channel status word, the descriptor pointer and three condition-select words. The sequencer reads those values to decide on interrupts, branches and waits. The sequencer itself, with descriptor fetch and data movement, sits outside this block.

Software never writes the status word directly. It writes the control slot, which carries a per-bit write mask in the upper half and new bit values in the lower half. The block merges the write into the status word and then derives the active and dead flags from the run, pause and wake bits.

Towards the sequencer, the block sends single-cycle strobes for start, flush and descriptor fetch. It takes back kill and stop events. A kill raises a level interrupt. That interrupt stays high until a separate acknowledge input clears it.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, the status word, the descriptor pointer, all select words, the interrupt and the three strobes are zero.
- R2: A control write (word slot 0, byte address 0x00) updates only those status bits whose mask bit (wdata[31:16]) is set. Only run (bit 15), pause (bit 14), flush (bit 13), wake (bit 12) and the device byte (bits 7:0) can be written this way. Dead (bit 11) and active (bit 10) cannot be written through the mask.
- R3: After the merge, a set wake bit turns active on. A set pause bit then turns active off, and this overrides wake and run.
- R4: When the merged word has run set, active is turned on and dead is cleared.
- R5: When a control write takes run from 1 to 0, both active and dead are cleared.
- R6: Reading the control slot returns zero. Slots 2 and 7 to 15 also read zero. So does any address with bits [1:0] nonzero or with a bit at position 6 or above set, and a write to such an address changes nothing.
- R7: A write to the descriptor pointer (slot 3, byte 0x0C) is ignored while run or active is set.
- R8: An accepted pointer write stores the value with bits [3:0] cleared and gives a one-cycle fetch strobe in the next cycle.
- R9: The interrupt, branch and wait select words (slots 4, 5, 6; bytes 0x10, 0x14, 0x18) read back the full 32-bit value last written. The status word reads back at slot 1 (byte 0x04), zero-extended.
- R10: A kill event sets dead, clears active and raises the interrupt. Kill takes precedence over a control write in the same cycle.
- R11: A stop event clears active, dead and flush, and leaves run unchanged.
- R12: The start strobe is high for one cycle after a control write that leaves active set. The flush strobe is high for one cycle after a control write that leaves flush set.
- R13: The interrupt stays high until irq_ack. A kill in the same cycle as irq_ack leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (7) | Byte address inside the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| seq_kill | input | 1 | Sequencer kill event |
| seq_stop | input | 1 | Sequencer stop event |
| irq_ack | input | 1 | Clears the interrupt |
| status_o | output | 16 | Status word |
| cmd_ptr_o | output | 32 | Descriptor pointer |
| int_sel_o | output | 32 | Interrupt condition select |
| br_sel_o | output | 32 | Branch condition select |
| wait_sel_o | output | 32 | Wait condition select |
| start_o | output | 1 | Start strobe to sequencer |
| flush_o | output | 1 | Flush strobe to sequencer |
| fetch_o | output | 1 | Descriptor fetch strobe |
| irq_o | output | 1 | Channel interrupt level |

## Verification
Two pairs of functions can land in the same clock cycle. In the first pair, a sequencer kill collides with a software control write. In the second, a kill collides with an interrupt acknowledge. The bench drives each pair in one cycle: a control write that sets run together with a kill, and a kill together with irq_ack. It then checks that the status word shows dead set and active cleared, that no start strobe appears, and that the interrupt stays high. A later acknowledge on its own must still clear the interrupt.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 7,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              seq_kill,
  input  logic              seq_stop,
  input  logic              irq_ack,
  output logic [DW/2-1:0]   status_o,
  output logic [DW-1:0]     cmd_ptr_o,
  output logic [DW-1:0]     int_sel_o,
  output logic [DW-1:0]     br_sel_o,
  output logic [DW-1:0]     wait_sel_o,
  output logic              start_o,
  output logic              flush_o,
  output logic              fetch_o,
  output logic              irq_o
);
  localparam int SW      = DW / 2;
  localparam int WIN_LSB = 6;
  localparam int B_RUN = 15, B_PAUSE = 14, B_FLUSH = 13, B_WAKE = 12, B_DEAD = 11, B_ACT = 10;
  localparam logic [SW-1:0] WMASK = 16'hF0FF;
  localparam logic [3:0] IDX_CTL = 4'd0, IDX_STAT = 4'd1, IDX_PTR = 4'd3,
                         IDX_ISEL = 4'd4, IDX_BSEL = 4'd5, IDX_WSEL = 4'd6;

  logic [SW-1:0] st_q, st_merge, st_nxt;
  logic [DW-1:0] ptr_q, isel_q, bsel_q, wsel_q;
  logic irq_q, start_q, flush_q, fetch_q;

  wire       hit    = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:WIN_LSB] == '0);
  wire [3:0] widx   = bus_addr[WIN_LSB-1:2];
  wire       wr_hit = bus_wr && hit;
  wire       ctl_wr = wr_hit && (widx == IDX_CTL);
  wire       ptr_wr = wr_hit && (widx == IDX_PTR) && !st_q[B_RUN] && !st_q[B_ACT];
  wire [SW-1:0] wmask = bus_wdata[DW-1:SW] & WMASK;

  always_comb begin
    st_merge = (bus_wdata[SW-1:0] & wmask) | (st_q & ~wmask);
    if (st_merge[B_WAKE]) st_merge[B_ACT] = 1'b1;
    if (st_merge[B_RUN]) begin
      st_merge[B_ACT]  = 1'b1;
      st_merge[B_DEAD] = 1'b0;
    end
    if (st_merge[B_PAUSE]) st_merge[B_ACT] = 1'b0;
    if (st_q[B_RUN] && !st_merge[B_RUN]) begin
      st_merge[B_ACT]  = 1'b0;
      st_merge[B_DEAD] = 1'b0;
    end
    st_nxt = ctl_wr ? st_merge : st_q;
    if (seq_stop) begin
      st_nxt[B_ACT]   = 1'b0;
      st_nxt[B_DEAD]  = 1'b0;
      st_nxt[B_FLUSH] = 1'b0;
    end
    if (seq_kill) begin
      st_nxt[B_DEAD] = 1'b1;
      st_nxt[B_ACT]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= '0;
      ptr_q   <= '0;
      isel_q  <= '0;
      bsel_q  <= '0;
      wsel_q  <= '0;
      irq_q   <= 1'b0;
      start_q <= 1'b0;
      flush_q <= 1'b0;
      fetch_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      start_q <= ctl_wr && st_nxt[B_ACT];
      flush_q <= ctl_wr && st_nxt[B_FLUSH];
      fetch_q <= ptr_wr;
      if (ptr_wr) ptr_q <= {bus_wdata[DW-1:4], 4'b0000};
      if (wr_hit && widx == IDX_ISEL) isel_q <= bus_wdata;
      if (wr_hit && widx == IDX_BSEL) bsel_q <= bus_wdata;
      if (wr_hit && widx == IDX_WSEL) wsel_q <= bus_wdata;
      if (seq_kill)     irq_q <= 1'b1;
      else if (irq_ack) irq_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      case (widx)
        IDX_STAT: bus_rdata = DW'(st_q);
        IDX_PTR:  bus_rdata = ptr_q;
        IDX_ISEL: bus_rdata = isel_q;
        IDX_BSEL: bus_rdata = bsel_q;
        IDX_WSEL: bus_rdata = wsel_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign status_o   = st_q;
  assign cmd_ptr_o  = ptr_q;
  assign int_sel_o  = isel_q;
  assign br_sel_o   = bsel_q;
  assign wait_sel_o = wsel_q;
  assign start_o    = start_q;
  assign flush_o    = flush_q;
  assign fetch_o    = fetch_q;
  assign irq_o      = irq_q;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wd_run_m,
  input logic              wd_run_v,
  input logic              seq_kill,
  input logic              seq_stop,
  input logic              irq_ack,
  input logic              st_run,
  input logic              st_act,
  input logic              st_dead,
  input logic              st_flush,
  input logic [31:0]       cmd_ptr_o,
  input logic              start_o,
  input logic              fetch_o,
  input logic              irq_o
);
  // R10
  kill_dead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_kill |=> st_dead && !st_act && irq_o);

  // R13
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !irq_ack |=> irq_o);

  // R7
  ptr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == ADDR_W'(12) && (st_run || st_act) |=> $stable(cmd_ptr_o) && !fetch_o);

  // R8
  fetch_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_o |-> cmd_ptr_o[3:0] == 4'd0 && $past(bus_wr));

  // R12
  start_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> st_act);

  // R5
  run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == '0 && st_run && wd_run_m && !wd_run_v && !seq_kill |=> !st_act && !st_dead);

  // R11
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_stop && !seq_kill |=> !st_act && !st_flush && !st_dead);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .wd_run_m(bus_wdata[31]), .wd_run_v(bus_wdata[15]),
  .seq_kill(seq_kill), .seq_stop(seq_stop), .irq_ack(irq_ack),
  .st_run(status_o[15]), .st_act(status_o[10]), .st_dead(status_o[11]),
  .st_flush(status_o[13]), .cmd_ptr_o(cmd_ptr_o), .start_o(start_o),
  .fetch_o(fetch_o), .irq_o(irq_o)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, seq_kill = 1'b0, seq_stop = 1'b0, irq_ack = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, cmd_ptr_o, int_sel_o, br_sel_o, wait_sel_o;
  logic [15:0] status_o;
  logic start_o, flush_o, fetch_o, irq_o;

  always #4 clk = ~clk;

  dma_chan_regs u0 (.*);

  localparam int O_RD = 0, O_ST = 1, O_PTR = 2, O_IRQ = 3, O_START = 4, O_FLUSH = 5, O_FETCH = 6;
  typedef struct { string req; int sel; logic [31:0] exp; } item_t;
  item_t sbq[$];
  event mon_ev;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] observe(int s);
    case (s)
      O_RD:    return bus_rdata;
      O_ST:    return {16'h0, status_o};
      O_PTR:   return cmd_ptr_o;
      O_IRQ:   return {31'h0, irq_o};
      O_START: return {31'h0, start_o};
      O_FLUSH: return {31'h0, flush_o};
      default: return {31'h0, fetch_o};
    endcase
  endfunction

  always begin
    @(mon_ev);
    while (sbq.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sbq.pop_front();
      act = observe(it.sel);
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic expect_o(string r, int s, logic [31:0] e);
    sbq.push_back('{r, s, e});
    -> mon_ev;
    #0.01;
  endtask

  task automatic rd_chk(string r, logic [6:0] a, logic [31:0] e);
    bus_addr = a;
    #0.01;
    expect_o(r, O_RD, e);
  endtask

  task automatic step(logic w, logic [6:0] a, logic [31:0] d, logic k, logic s, logic ak);
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; seq_kill = k; seq_stop = s; irq_ack = ak;
    @(negedge clk);
    bus_wr = 0; seq_kill = 0; seq_stop = 0; irq_ack = 0;
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d); step(1, a, d, 0, 0, 0); endtask
  task automatic ctl(logic [15:0] m, logic [15:0] v); step(1, 7'h00, {m, v}, 0, 0, 0); endtask
  task automatic idle(); step(0, bus_addr, 32'h0, 0, 0, 0); endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #0.01;
    // R1
    expect_o("R1 status", O_ST, 0);
    expect_o("R1 ptr", O_PTR, 0);
    expect_o("R1 irq", O_IRQ, 0);
    expect_o("R1 start", O_START, 0);
    expect_o("R1 flush", O_FLUSH, 0);
    expect_o("R1 fetch", O_FETCH, 0);
    rd_chk("R1 sel", 7'h10, 0);

    // R9
    wr(7'h10, 32'h000F_0005);
    wr(7'h14, 32'h0003_0001);
    wr(7'h18, 32'h1234_5678);
    rd_chk("R9 int sel", 7'h10, 32'h000F_0005);
    rd_chk("R9 br sel", 7'h14, 32'h0003_0001);
    rd_chk("R9 wait sel", 7'h18, 32'h1234_5678);

    // R8
    wr(7'h0C, 32'h0000_1237);
    expect_o("R8 fetch pulse", O_FETCH, 1);
    expect_o("R8 aligned ptr", O_PTR, 32'h0000_1230);
    idle();
    expect_o("R8 fetch one cycle", O_FETCH, 0);

    // R2
    ctl(16'h00FF, 16'h00A5);
    expect_o("R2 device byte", O_ST, 32'h00A5);
    ctl(16'h0F00, 16'h0F00);
    expect_o("R2 dead/active not writable", O_ST, 32'h00A5);
    expect_o("R2 no start", O_START, 0);
    ctl(16'h0000, 16'hFFFF);
    expect_o("R2 zero mask", O_ST, 32'h00A5);

    // R3 R12
    ctl(16'h1000, 16'h1000);
    expect_o("R3 wake forces active", O_ST, 32'h14A5);
    expect_o("R12 start pulse", O_START, 1);
    idle();
    expect_o("R12 start one cycle", O_START, 0);
    ctl(16'h4000, 16'h4000);
    expect_o("R3 pause beats wake", O_ST, 32'h50A5);
    ctl(16'h5000, 16'h0000);
    expect_o("R3 clear wake pause", O_ST, 32'h00A5);

    // R10 R13
    step(0, 7'h00, 0, 1, 0, 0);
    expect_o("R10 kill status", O_ST, 32'h08A5);
    expect_o("R10 kill irq", O_IRQ, 1);
    idle(); idle();
    expect_o("R13 irq held", O_IRQ, 1);
    step(0, 7'h00, 0, 0, 0, 1);
    expect_o("R13 ack clears", O_IRQ, 0);

    // R4
    ctl(16'h8000, 16'h8000);
    expect_o("R4 run active undead", O_ST, 32'h84A5);
    expect_o("R4 start", O_START, 1);

    // R7
    wr(7'h0C, 32'h0000_5550);
    expect_o("R7 no fetch while run", O_FETCH, 0);
    rd_chk("R7 ptr kept while run", 7'h0C, 32'h0000_1230);

    // R12 flush
    ctl(16'h2000, 16'h2000);
    expect_o("R12 flush pulse", O_FLUSH, 1);
    expect_o("R12 flush status", O_ST, 32'hA4A5);
    idle();
    expect_o("R12 flush one cycle", O_FLUSH, 0);

    // R11
    step(0, 7'h00, 0, 0, 1, 0);
    expect_o("R11 stop clears", O_ST, 32'h80A5);

    // R10 kill with control write in same cycle
    step(1, 7'h00, {16'h00FF, 16'h005A}, 1, 0, 0);
    expect_o("R10 kill beats write", O_ST, 32'h885A);
    expect_o("R10 no start on kill", O_START, 0);
    expect_o("R10 irq", O_IRQ, 1);

    // R13 kill with ack in same cycle
    step(0, 7'h00, 0, 1, 0, 1);
    expect_o("R13 kill beats ack", O_IRQ, 1);
    step(0, 7'h00, 0, 0, 0, 1);
    expect_o("R13 ack alone", O_IRQ, 0);

    // R5
    ctl(16'h8000, 16'h0000);
    expect_o("R5 run fall clears dead", O_ST, 32'h005A);
    ctl(16'h8000, 16'h8000);
    expect_o("R4 run again", O_ST, 32'h845A);
    ctl(16'h8000, 16'h0000);
    expect_o("R5 run fall clears active", O_ST, 32'h005A);

    // R7 active only
    ctl(16'h1000, 16'h1000);
    expect_o("R3 wake again", O_ST, 32'h145A);
    wr(7'h0C, 32'h0000_7777);
    rd_chk("R7 ptr kept while active", 7'h0C, 32'h0000_1230);
    step(0, 7'h00, 0, 0, 1, 0);
    expect_o("R11 stop keeps wake", O_ST, 32'h105A);
    ctl(16'h1000, 16'h0000);
    wr(7'h0C, 32'hFFFF_FFFF);
    expect_o("R8 ptr low bits cleared", O_PTR, 32'hFFFF_FFF0);
    expect_o("R8 fetch", O_FETCH, 1);

    // R6
    rd_chk("R6 control reads zero", 7'h00, 0);
    rd_chk("R6 slot 2 zero", 7'h08, 0);
    rd_chk("R6 slot 7 zero", 7'h1C, 0);
    rd_chk("R6 slot 9 zero", 7'h24, 0);
    rd_chk("R6 outside window", 7'h4C, 0);
    rd_chk("R6 unaligned", 7'h0D, 0);
    wr(7'h4C, 32'h0000_0100);
    wr(7'h11, 32'hDEAD_BEEF);
    rd_chk("R6 outside write ignored", 7'h0C, 32'hFFFF_FFF0);
    rd_chk("R6 unaligned write ignored", 7'h10, 32'h000F_0005);
    rd_chk("R9 status readback", 7'h04, 32'h005A);

    // R3 pause with run
    ctl(16'hC000, 16'hC000);
    expect_o("R3 pause beats run", O_ST, 32'hC05A);
    expect_o("R3 no start under pause", O_START, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule